// File: doc/BRIEF.md
# Indexed Register Slave for a Two-Wire Serial Bus

This block sits on an SMBus/I2C-style two-wire bus as a target device and gives a host access to a 32-byte configuration register file that lives outside the block. A system clock samples the SCL and SDA lines; the block never drives a line high. It only asserts an open-drain pull-down enable on SDA. Register contents reach the file through a one-cycle write strobe. They are fetched through a combinational read port whose index the block supplies.

Every transfer begins with a write-direction address byte (D2h), followed by a starting offset. A write then carries a byte count and that many data bytes. A read switches direction with a repeated START and the read-direction address byte (D3h). The block then returns a stored byte count before the data. The offset advances after every data byte. Offsets marked read-only accept data on the bus but never reach the file. A zero count is rejected. The host may end a read early with a NACK, or with a STOP placed in the acknowledge slot.

Top module: `smb_idx_slave`

## Requirements
- R1: The block acknowledges only an address byte whose upper seven bits equal the device address (default 69h, so D2h writes and D3h reads). Any other address is NACKed, and SDA is left released until the next START or STOP.
- R2: In a write, the byte after D2h sets the offset and the next byte sets the count N. Each of the N data bytes is ACKed and written to the file at offset, offset+1, and so on, wrapping modulo 32. Each byte gives exactly one single-cycle strobe, and N=01h gives a single-byte write.
- R3: Data bytes beyond the N announced in a write are NACKed and are not written.
- R4: A count byte of zero is NACKed. All following bytes up to the next STOP are NACKed and ignored, and the stored read-back count is not changed.
- R5: After a repeated START and D3h, the first byte returned is the stored count, which is 8 after reset and is replaced by every valid write count. The data bytes follow, starting at the current offset. Every byte is sent MSB first.
- R6: In a read, once the stored count of data bytes has been sent, any further byte the host clocks out reads as FFh with SDA released.
- R7: A host NACK ends the read and leaves SDA released. A STOP in the acknowledge slot also ends it. The offset has then advanced by the number of data bytes actually sent, so a later read without a new offset continues from there.
- R8: Offsets flagged read-only (default 6 and 7) ACK their data bytes and advance the offset, but produce no write strobe.
- R9: A START seen in the middle of a transfer releases SDA and restarts address decoding. Data already written stays written.
- R10: A STOP returns the block to idle with SDA released. The SDA enable changes only while SCL is low.
- R11: Out of reset the SDA enable and the write strobe are both low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, samples the bus lines |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | Pull SDA low when 1 (open-drain enable) |
| reg_wr_en | output | 1 | Single-cycle write strobe to the register file |
| reg_wr_addr | output | 5 | Register index for the write |
| reg_wr_data | output | 8 | Byte to write |
| reg_rd_addr | output | 5 | Register index being read |
| reg_rd_data | input | 8 | Combinational read data for reg_rd_addr |

## Verification
The bench targets the count byte and the edges of the count. A zero count that was acknowledged would let the following data bytes corrupt the file. Bytes past N that were not NACKed would write one register too many. A read past the count that did not return FFh would leak neighbouring registers. It ends reads early in both legal ways: a NACK, and a STOP placed in the acknowledge slot. A pointer that advanced on the prefetch rather than on bytes actually sent would make the following pointer-less read start one register late. Read-only offsets, offset wrap at 31, a wrong address, and a START in the middle of a write are also driven. Any of these can expose a design that writes masked bytes, loses the wrap, answers another device's address, or keeps decoding a dead transfer.

// File: rtl/smb_pkg.sv
// Package: shared types for the indexed two-wire register slave.
// Assumes one byte per bus transfer and synchronous sampling of both lines.
package smb_pkg;

    localparam int BYTE_W = 8;

    // Bus-level events produced by the line synchronizer
    typedef struct packed {
        logic start;   // SDA fell while SCL high
        logic stop;    // SDA rose while SCL high
        logic rise;    // SCL rising edge
        logic fall;    // SCL falling edge
        logic sda;     // synchronized SDA level
    } smb_line_ev_t;

    // Bit-engine states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_HOLD
    } smb_state_e;

    // Meaning of the next byte received from the host
    typedef enum logic [1:0] {
        PH_ADDR,
        PH_OFFSET,
        PH_COUNT,
        PH_DATA
    } smb_phase_e;

endpackage

// File: rtl/smb_line_sync.sv
// Module: smb_line_sync
// Brings SCL and SDA into the clk domain through SYNC_STAGES flops each and
// derives START, STOP and SCL edge events from the synchronized levels.
// Assumes the bus is idle-high and SCL is slow against clk (several clks per phase).
module smb_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_i,
    input  logic                 sda_i,
    output smb_pkg::smb_line_ev_t ev,
    output logic                 scl_lvl
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] scl_sr;
    logic [SYNC_STAGES-1:0] sda_sr;
    logic                   scl_q;
    logic                   sda_q;
    logic                   scl_s;
    logic                   sda_s;

    // Synchronizer chains, reset to the idle-high bus level
    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_sr <= '1;
                    sda_sr <= '1;
                end else begin
                    scl_sr <= scl_i;
                    sda_sr <= sda_i;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_sr <= '1;
                    sda_sr <= '1;
                end else begin
                    scl_sr <= {scl_sr[TOP-1:0], scl_i};
                    sda_sr <= {sda_sr[TOP-1:0], sda_i};
                end
            end
        end
    endgenerate

    assign scl_s = scl_sr[TOP];
    assign sda_s = sda_sr[TOP];

    // One-cycle history of the synchronized levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // Event decode from current and previous synchronized levels
    always_comb begin
        ev.start = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop  = scl_s & scl_q & ~sda_q & sda_s;
        ev.rise  = scl_s & ~scl_q;
        ev.fall  = ~scl_s & scl_q;
        ev.sda   = sda_s;
    end

    assign scl_lvl = scl_s;

endmodule

// File: rtl/smb_proto_fsm.sv
// Module: smb_proto_fsm
// Bit and byte engine of the indexed slave: decodes address, offset and count,
// issues write requests, serializes the count and read data, and decides ACK/NACK.
// Assumes events from smb_line_sync; SDA only changes on detected SCL falls.
module smb_proto_fsm
    import smb_pkg::*;
#(
    parameter int                REG_AW   = 5,
    parameter logic [6:0]        DEV_ADDR = 7'h69,
    parameter logic [BYTE_W-1:0] CNT_RST  = 8'd8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  smb_line_ev_t      ev,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [REG_AW-1:0] rd_idx,
    output logic              wr_req,
    output logic [REG_AW-1:0] wr_idx,
    output logic [BYTE_W-1:0] wr_byte,
    output logic              sda_oe
);
    localparam int          BIT_CW  = $clog2(BYTE_W + 1);
    localparam logic [BIT_CW-1:0] LAST_RX = BIT_CW'(BYTE_W);
    localparam logic [BIT_CW-1:0] LAST_TX = BIT_CW'(BYTE_W - 1);

    smb_state_e        state;
    smb_phase_e        phase;
    logic [BIT_CW-1:0] bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] txsh;
    logic [REG_AW-1:0] ptr;
    logic [BYTE_W-1:0] remain;
    logic [BYTE_W-1:0] rd_cnt;
    logic              ack_q;
    logic              go_tx;
    logic              addr_hit;

    assign addr_hit = (shreg[BYTE_W-1:1] == DEV_ADDR);
    assign rd_idx   = ptr;

    // Protocol state machine: one branch per bus event, START and STOP win
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            phase   <= PH_ADDR;
            bitcnt  <= '0;
            shreg   <= '0;
            txsh    <= '1;
            ptr     <= '0;
            remain  <= '0;
            rd_cnt  <= CNT_RST;
            ack_q   <= 1'b0;
            go_tx   <= 1'b0;
            sda_oe  <= 1'b0;
            wr_req  <= 1'b0;
            wr_idx  <= '0;
            wr_byte <= '0;
        end else begin
            wr_req <= 1'b0;
            if (ev.start) begin
                state  <= ST_RX;
                phase  <= PH_ADDR;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (ev.stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                unique case (state)
                    ST_RX: begin
                        if (ev.rise) begin
                            shreg  <= {shreg[BYTE_W-2:0], ev.sda};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (ev.fall && bitcnt == LAST_RX) begin
                            state <= ST_RX_ACK;
                            ack_q <= 1'b0;
                            go_tx <= 1'b0;
                            unique case (phase)
                                PH_ADDR: begin
                                    if (addr_hit) begin
                                        ack_q  <= 1'b1;
                                        sda_oe <= 1'b1;
                                        if (shreg[0]) begin
                                            go_tx  <= 1'b1;
                                            txsh   <= rd_cnt;
                                            remain <= rd_cnt;
                                        end else begin
                                            phase <= PH_OFFSET;
                                        end
                                    end
                                end
                                PH_OFFSET: begin
                                    ptr    <= shreg[REG_AW-1:0];
                                    ack_q  <= 1'b1;
                                    sda_oe <= 1'b1;
                                    phase  <= PH_COUNT;
                                end
                                PH_COUNT: begin
                                    if (shreg != '0) begin
                                        remain <= shreg;
                                        rd_cnt <= shreg;
                                        ack_q  <= 1'b1;
                                        sda_oe <= 1'b1;
                                        phase  <= PH_DATA;
                                    end
                                end
                                PH_DATA: begin
                                    if (remain != '0) begin
                                        ack_q   <= 1'b1;
                                        sda_oe  <= 1'b1;
                                        wr_req  <= 1'b1;
                                        wr_idx  <= ptr;
                                        wr_byte <= shreg;
                                        ptr     <= ptr + 1'b1;
                                        remain  <= remain - 1'b1;
                                    end
                                end
                                default: ;
                            endcase
                        end
                    end
                    ST_RX_ACK: begin
                        if (ev.fall) begin
                            bitcnt <= '0;
                            if (!ack_q) begin
                                state  <= ST_HOLD;
                                sda_oe <= 1'b0;
                            end else if (go_tx) begin
                                state  <= ST_TX;
                                sda_oe <= ~txsh[BYTE_W-1];
                            end else begin
                                state  <= ST_RX;
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_TX: begin
                        if (ev.fall) begin
                            if (bitcnt == LAST_TX) begin
                                state  <= ST_TX_ACK;
                                sda_oe <= 1'b0;
                                bitcnt <= '0;
                            end else begin
                                txsh   <= {txsh[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~txsh[BYTE_W-2];
                                bitcnt <= bitcnt + 1'b1;
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (ev.rise && ev.sda) begin
                            state <= ST_HOLD;
                        end else if (ev.fall) begin
                            state <= ST_TX;
                            if (remain != '0) begin
                                txsh   <= rd_data;
                                sda_oe <= ~rd_data[BYTE_W-1];
                                ptr    <= ptr + 1'b1;
                                remain <= remain - 1'b1;
                            end else begin
                                txsh   <= '1;
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/smb_wr_gate.sv
// Module: smb_wr_gate
// Registers write requests towards the register file and drops any request
// aimed at an index flagged read-only in RO_MASK.
// Assumes at most one request per clk; the strobe lasts one clk.
module smb_wr_gate #(
    parameter int                       REG_AW  = 5,
    parameter logic [(1<<REG_AW)-1:0]   RO_MASK = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [REG_AW-1:0] idx,
    input  logic [7:0]        din,
    output logic              wr_en,
    output logic [REG_AW-1:0] wr_addr,
    output logic [7:0]        wr_data
);
    localparam int REG_NUM = 1 << REG_AW;

    logic [REG_NUM-1:0] writable;

    // Per-register write permission derived from the read-only mask
    generate
        for (genvar i = 0; i < REG_NUM; i++) begin : g_perm
            assign writable[i] = ~RO_MASK[i];
        end
    endgenerate

    // Output register for the file write port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en   <= req & writable[idx];
            wr_addr <= idx;
            wr_data <= din;
        end
    end

endmodule

// File: rtl/smb_idx_slave.sv
// Module: smb_idx_slave (top)
// Two-wire bus slave with indexed block/byte read and write into an external
// 32-byte register file. Chains line synchronizer, protocol engine and write gate.
// Assumes SCL phases span several clk periods; no clock stretching is done.
module smb_idx_slave #(
    parameter int                     REG_AW      = 5,
    parameter int                     SYNC_STAGES = 2,
    parameter logic [6:0]             DEV_ADDR    = 7'h69,
    parameter logic [7:0]             CNT_RST     = 8'd8,
    parameter logic [(1<<REG_AW)-1:0] RO_MASK     = 'hC0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic              reg_wr_en,
    output logic [REG_AW-1:0] reg_wr_addr,
    output logic [7:0]        reg_wr_data,
    output logic [REG_AW-1:0] reg_rd_addr,
    input  logic [7:0]        reg_rd_data
);
    smb_pkg::smb_line_ev_t line_ev;
    logic                  scl_lvl;
    logic                  wr_req;
    logic [REG_AW-1:0]     wr_idx;
    logic [7:0]            wr_byte;

    smb_line_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl_i),
        .sda_i  (sda_i),
        .ev     (line_ev),
        .scl_lvl(scl_lvl)
    );

    smb_proto_fsm #(
        .REG_AW  (REG_AW),
        .DEV_ADDR(DEV_ADDR),
        .CNT_RST (CNT_RST)
    ) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev     (line_ev),
        .rd_data(reg_rd_data),
        .rd_idx (reg_rd_addr),
        .wr_req (wr_req),
        .wr_idx (wr_idx),
        .wr_byte(wr_byte),
        .sda_oe (sda_oe)
    );

    smb_wr_gate #(
        .REG_AW (REG_AW),
        .RO_MASK(RO_MASK)
    ) u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (wr_req),
        .idx    (wr_idx),
        .din    (wr_byte),
        .wr_en  (reg_wr_en),
        .wr_addr(reg_wr_addr),
        .wr_data(reg_wr_data)
    );

endmodule

// File: rtl/smb_idx_slave_chk.sv
// Module: smb_idx_slave_chk
// Property checker bound into smb_idx_slave; observes ports and the
// synchronized line events only.
module smb_idx_slave_chk #(
    parameter int                     REG_AW  = 5,
    parameter logic [(1<<REG_AW)-1:0] RO_MASK = 'hC0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_s,
    input logic              start_ev,
    input logic              stop_ev,
    input logic              sda_oe,
    input logic              reg_wr_en,
    input logic [REG_AW-1:0] reg_wr_addr
);
    AST_RO_NEVER_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> !RO_MASK[reg_wr_addr]); // R8

    AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en); // R2

    AST_SDA_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_oe)); // R10

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !sda_oe); // R10

    AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> !sda_oe); // R9

endmodule

bind smb_idx_slave smb_idx_slave_chk #(
    .REG_AW (REG_AW),
    .RO_MASK(RO_MASK)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_s      (scl_lvl),
    .start_ev   (line_ev.start),
    .stop_ev    (line_ev.stop),
    .sda_oe     (sda_oe),
    .reg_wr_en  (reg_wr_en),
    .reg_wr_addr(reg_wr_addr)
);

// File: tb/smb_idx_slave_test.sv
// Bench for smb_idx_slave: bit-level bus master, register file model, and
// expected values from a shadow file maintained from the requirements.
module smb_idx_slave_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam logic [31:0] RO_TB = 32'h0000_00C0; // R8: offsets 6 and 7
    localparam logic [7:0]  WR_ADDR = 8'hD2;
    localparam logic [7:0]  RD_ADDR = 8'hD3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_oe;
    logic       reg_wr_en;
    logic [4:0] reg_wr_addr;
    logic [7:0] reg_wr_data;
    logic [4:0] reg_rd_addr;
    logic [7:0] reg_rd_data;
    logic       sda_line;

    logic [7:0] rf     [32];
    logic [7:0] exp_rf [32];
    logic [7:0] wdat   [8];
    int         exp_cnt = 8;
    int         eptr = 0;
    int         checks = 0;
    int         errors = 0;
    int         scl_viol = 0;
    logic       prev_scl = 1'b1;
    logic       prev_oe = 1'b0;

    assign sda_line    = m_sda & ~sda_oe;
    assign reg_rd_data = rf[reg_rd_addr];

    always #(CLK_PERIOD/2) clk = ~clk;

    smb_idx_slave uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (m_scl),
        .sda_i      (sda_line),
        .sda_oe     (sda_oe),
        .reg_wr_en  (reg_wr_en),
        .reg_wr_addr(reg_wr_addr),
        .reg_wr_data(reg_wr_data),
        .reg_rd_addr(reg_rd_addr),
        .reg_rd_data(reg_rd_data)
    );

    function automatic logic [7:0] init_val(int i);
        return 8'((i * 37 + 5) & 8'hFF);
    endfunction

    function automatic logic [7:0] exp_read(int i, int cnt, int p);
        return (i < cnt) ? exp_rf[p] : 8'hFF;
    endfunction

    // Register file owned by the bench, written through the block's port
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) rf[i] <= init_val(i);
        end else if (reg_wr_en) begin
            rf[reg_wr_addr] <= reg_wr_data;
        end
    end

    // R10 monitor: SDA enable must not move while SCL is held high
    always @(negedge clk) begin
        if (rst_n && m_scl && prev_scl && (sda_oe != prev_oe)) scl_viol++;
        prev_scl = m_scl;
        prev_oe  = sda_oe;
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(HALF);
        m_scl = 1'b1; tick(HALF);
        m_sda = 1'b0; tick(HALF);
        m_scl = 1'b0; tick(2);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(HALF);
        m_scl = 1'b1; tick(HALF);
        m_sda = 1'b1; tick(HALF);
    endtask

    task automatic send_bit(logic b);
        m_sda = b;    tick(HALF);
        m_scl = 1'b1; tick(HALF);
        m_scl = 1'b0; tick(2);
    endtask

    task automatic recv_bit(output logic b);
        m_sda = 1'b1; tick(HALF);
        m_scl = 1'b1; tick(HALF/2);
        b = sda_line; tick(HALF/2);
        m_scl = 1'b0; tick(2);
    endtask

    task automatic write_byte(logic [7:0] d, output bit ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(b);
        ack = ~b;
    endtask

    task automatic read_byte(bit ack_m, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            d[i] = b;
        end
        send_bit(~ack_m);
    endtask

    // Write transfer: count n announced, nsend data bytes from wdat
    task automatic do_write(int off, int n, int nsend, bit stop_end, string req);
        bit ack;
        bus_start();
        write_byte(WR_ADDR, ack);
        chk(ack, "R1", "write address ack", ack, 1);
        write_byte(8'(off), ack);
        chk(ack, req, "offset ack", ack, 1);
        eptr = off;
        write_byte(8'(n), ack);
        chk(ack == (n != 0), (n == 0) ? "R4" : req, "count ack", ack, (n != 0));
        if (n != 0) exp_cnt = n;
        for (int i = 0; i < nsend; i++) begin
            bit exp_ack;
            exp_ack = (n != 0) && (i < n);
            write_byte(wdat[i], ack);
            chk(ack == exp_ack, (n == 0) ? "R4" : ((i < n) ? req : "R3"),
                "data ack", ack, exp_ack);
            if (exp_ack) begin
                if (!RO_TB[eptr]) exp_rf[eptr] = wdat[i];
                eptr = (eptr + 1) % 32;
            end
        end
        if (stop_end) bus_stop();
    endtask

    // Read transfer: optional offset phase, count byte, nread data bytes
    task automatic do_read(bit set_off, int off, int nread, string req);
        bit ack;
        logic [7:0] d;
        int cnt;
        bus_start();
        if (set_off) begin
            write_byte(WR_ADDR, ack);
            chk(ack, "R1", "write address ack", ack, 1);
            write_byte(8'(off), ack);
            chk(ack, req, "offset ack", ack, 1);
            eptr = off;
            bus_start();
        end
        write_byte(RD_ADDR, ack);
        chk(ack, "R1", "read address ack", ack, 1);
        cnt = exp_cnt;
        read_byte(nread != 0, d);
        chk(d == 8'(cnt), "R5", "count byte", d, cnt);
        for (int i = 0; i < nread; i++) begin
            logic [7:0] e;
            e = exp_read(i, cnt, eptr);
            read_byte(i < nread - 1, d);
            chk(d == e, (i < cnt) ? req : "R6", "read data", d, e);
            if (i < cnt) eptr = (eptr + 1) % 32;
        end
        bus_stop();
    endtask

    task automatic chk_file(string req);
        int bad;
        bad = 0;
        for (int i = 0; i < 32; i++) if (rf[i] !== exp_rf[i]) bad++;
        chk(bad == 0, req, "register file mismatches", bad, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run hung actual=%0d expected=%0d", 150000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        bit ack;
        logic [7:0] d;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 32; i++) exp_rf[i] = init_val(i);
        tick(5);
        rst_n = 1'b1;
        tick(3);
        // R11: quiet after reset
        chk(sda_oe == 1'b0, "R11", "sda_oe after reset", sda_oe, 0);
        chk(reg_wr_en == 1'b0, "R11", "wr strobe after reset", reg_wr_en, 0);

        // R5: reset count is 8, data from offset 0
        do_read(1, 0, 3, "R5");

        // R2: block write of four bytes, read back
        wdat[0] = 8'hA5; wdat[1] = 8'h3C; wdat[2] = 8'h00; wdat[3] = 8'hFF;
        do_write(16, 4, 4, 1, "R2");
        chk_file("R2");
        do_read(1, 16, 4, "R5");

        // R1: foreign address is NACKed and nothing is driven afterwards
        bus_start();
        write_byte(8'hA0, ack);
        chk(!ack, "R1", "foreign address nack", ack, 0);
        write_byte(8'h00, ack);
        chk(!ack, "R1", "byte after foreign address", ack, 0);
        bus_stop();
        chk_file("R1");

        // R4: zero count rejected, data ignored, count kept
        wdat[0] = 8'h11; wdat[1] = 8'h22;
        do_write(2, 0, 2, 1, "R4");
        chk_file("R4");
        do_read(1, 2, 1, "R4");

        // R3: third byte beyond count of 2
        wdat[0] = 8'h5A; wdat[1] = 8'h6B; wdat[2] = 8'h7C;
        do_write(20, 2, 3, 1, "R3");
        chk_file("R3");

        // R6: reading past the count returns FFh
        do_read(1, 20, 4, "R6");

        // R8: offsets 6 and 7 are read-only
        wdat[0] = 8'h01; wdat[1] = 8'h02; wdat[2] = 8'h03; wdat[3] = 8'h04;
        do_write(5, 4, 4, 1, "R8");
        chk_file("R8");
        do_read(1, 5, 4, "R8");

        // R2: offset wraps from 31 to 0, single-byte write with count 01h
        wdat[0] = 8'hC1; wdat[1] = 8'hC2;
        do_write(31, 2, 2, 1, "R2");
        chk_file("R2");
        wdat[0] = 8'h9E;
        do_write(12, 1, 1, 1, "R2");
        chk_file("R2");

        // R7: host NACK after first data byte, then read without offset
        wdat[0] = 8'h10; wdat[1] = 8'h20; wdat[2] = 8'h30; wdat[3] = 8'h40;
        do_write(24, 4, 4, 1, "R2");
        do_read(1, 24, 1, "R7");
        do_read(0, 0, 2, "R7");

        // R7: STOP placed in the ACK slot after one data byte
        bus_start();
        write_byte(WR_ADDR, ack);
        write_byte(8'd24, ack);
        bus_start();
        write_byte(RD_ADDR, ack);
        read_byte(1, d);
        chk(d == 8'(exp_cnt), "R5", "count byte", d, exp_cnt);
        for (int i = 7; i >= 0; i--) recv_bit(ack);
        m_sda = 1'b0; tick(HALF);
        m_scl = 1'b1; tick(HALF);
        m_sda = 1'b1; tick(HALF);
        chk(sda_oe == 1'b0, "R10", "sda released after stop", sda_oe, 0);
        eptr = 25;
        do_read(0, 0, 1, "R7");

        // R9: START in the middle of a write restarts decoding
        wdat[0] = 8'h77;
        do_write(3, 3, 1, 0, "R9");
        wdat[0] = 8'h88;
        do_write(9, 1, 1, 1, "R9");
        chk_file("R9");

        // Random write/read pairs
        for (int it = 0; it < 24; it++) begin
            int off;
            int n;
            off = int'($urandom % 32);
            n   = 1 + int'($urandom % 4);
            for (int k = 0; k < n; k++) wdat[k] = 8'($urandom);
            do_write(off, n, n, 1, "R2");
            do_read(1, off, n + int'($urandom % 2), "R5");
        end
        chk_file("R2");
        chk(scl_viol == 0, "R10", "sda_oe changes while SCL high", scl_viol, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule